// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Update Masks

This block is the purely combinational arithmetic and logic unit of a small 8-bit accumulator processor. Each cycle the surrounding datapath presents an operation code, the accumulator value, a second operand fetched from memory, and the current carry and decimal-mode flags. The block returns an 8-bit result together with candidate values for the negative, overflow, zero and carry flags. It also returns a separate update enable for each of those flags.

The status register outside the block loads only the flags whose enables are high. This lets every operation touch exactly the flags it owns. Addition and subtraction work in plain binary, or on two packed decimal digits when the decimal input is high. Subtraction treats the carry as an inverted borrow. Compare and bit test produce flags only and hand the accumulator back unchanged.

Top module: `alu8_core`

## Requirements
- R1: `op_sel` codes 11 to 15 are unused. They return `acc_in` on `result` with all four update enables low. For every operation, a flag output whose update enable is low is driven 0.
- R2: Code 0 with `dec_in`=0 is add with carry. `result` = (A + M + C) mod 256. C is the carry out of bit 7. V=1 when the signed sum leaves -128..+127. N is result bit 7 and Z is (result == 0). All four enables are high.
- R3: Code 1 with `dec_in`=0 is subtract: `result` = (A - M - (1 - C)) mod 256. C=1 when no borrow occurred, V=1 on signed overflow, and N and Z follow the result. All four enables are high.
- R4: Code 0 with `dec_in`=1 adds two-digit packed decimal values: the high nibble holds the tens digit and the low nibble the ones digit. `result` holds the decimal sum mod 100, and C is the decimal carry out of the tens digit. N, Z and V come from the binary sum of the same operands.
- R5: Code 1 with `dec_in`=1 subtracts packed decimal values. `result` is (A - M - (1 - C)) mod 100 in packed decimal, and C=0 exactly when a borrow was taken. N, Z and V come from the binary difference.
- R6: Codes 2, 3 and 4 return A AND M, A OR M and A XOR M. Only N and Z are updated, from the result.
- R7: Code 5 shifts left, with 0 into bit 0 and old bit 7 into C. Code 6 shifts right, with 0 into bit 7 and old bit 0 into C. N, Z and C are updated.
- R8: Code 7 rotates left, with C into bit 0 and old bit 7 into C. Code 8 rotates right, with C into bit 7 and old bit 0 into C. N, Z and C are updated.
- R9: Code 9 compares. `result` = A. Z = (A == M) and C = (A >= M) unsigned, and N is bit 7 of (A - M) mod 256. Carry and decimal inputs are ignored. N, Z and C are updated.
- R10: Code 10 is bit test. `result` = A, Z = ((A AND M) == 0), N = M bit 7 and V = M bit 6. N, V and Z are updated.
- R11: `dec_in` has no effect on any code other than 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand (A) |
| mem_in | input | 8 | Memory operand (M) |
| carry_in | input | 1 | Current carry flag |
| dec_in | input | 1 | Current decimal-mode flag |
| result | output | 8 | Operation result |
| n_out | output | 1 | Negative flag value |
| v_out | output | 1 | Overflow flag value |
| z_out | output | 1 | Zero flag value |
| c_out | output | 1 | Carry flag value |
| upd_n | output | 1 | Load enable for N |
| upd_v | output | 1 | Load enable for V |
| upd_z | output | 1 | Load enable for Z |
| upd_c | output | 1 | Load enable for C |

## Verification
The embedded assertions only judge vectors whose inputs are fully known. They make no claim about decimal results, because a decimal outcome is defined only when both operands hold valid digits. The stimulus applies decimal add and subtract only to operand pairs whose nibbles are both 0 to 9. It sweeps every such pair with both carry values. All other codes, including the unused ones, are swept over a strided grid of binary operands with both carry values and both decimal settings, so that any influence of the decimal input outside add and subtract shows up at the outputs.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_ROL = 4'd7,
    OP_ROR = 4'd8,
    OP_CMP = 4'd9,
    OP_BIT = 4'd10
  } alu_op_e;

  localparam logic [OP_W-1:0] OP_LAST = OP_BIT;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic          subtract,
  input  logic          decimal,
  input  logic          cin,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum,
  output logic [DW-1:0] bin_sum,
  output logic          cout,
  output logic          ovf
);
  localparam int ND = DW / 4;

  logic [DW-1:0] b_eff;
  logic [DW:0]   wide;
  logic [DW-1:0] dsum;
  logic [ND:0]   dcy;

  // Binary path: subtraction is A + ~M + C
  always_comb begin
    b_eff = subtract ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
  end

  assign bin_sum = wide[DW-1:0];
  assign ovf     = ~(a[DW-1] ^ b_eff[DW-1]) & (a[DW-1] ^ wide[DW-1]);

  // Decimal path: carry (add) or borrow (sub) ripples through the digits
  assign dcy[0] = subtract ? ~cin : cin;

  for (genvar g = 0; g < ND; g++) begin : g_digit
    logic [4:0] raw;
    logic [4:0] fix;
    logic       co;
    always_comb begin
      if (subtract) begin
        raw = {1'b0, a[4*g +: 4]} - {1'b0, b[4*g +: 4]} - {4'd0, dcy[g]};
        co  = raw[4];
        fix = co ? (raw - 5'd6) : raw;
      end else begin
        raw = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'd0, dcy[g]};
        co  = (raw > 5'd9);
        fix = co ? (raw + 5'd6) : raw;
      end
    end
    assign dsum[4*g +: 4] = fix[3:0];
    assign dcy[g+1]       = co;
  end

  always_comb begin
    if (decimal) begin
      sum  = dsum;
      cout = subtract ? ~dcy[ND] : dcy[ND];
    end else begin
      sum  = bin_sum;
      cout = wide[DW];
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int DW = 8
) (
  input  logic [1:0]    sel,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    case (sel)
      2'd1:    y = a | b;
      2'd2:    y = a ^ b;
      default: y = a & b;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int DW = 8
) (
  input  logic [1:0]    mode,
  input  logic          cin,
  input  logic [DW-1:0] a,
  output logic [DW-1:0] y,
  output logic          cout
);
  localparam int MSB = DW - 1;

  // mode: 0 shift left, 1 shift right, 2 rotate left, 3 rotate right
  always_comb begin
    case (mode)
      2'd0: begin y = {a[MSB-1:0], 1'b0}; cout = a[MSB]; end
      2'd1: begin y = {1'b0, a[MSB:1]};   cout = a[0];   end
      2'd2: begin y = {a[MSB-1:0], cin};  cout = a[MSB]; end
      default: begin y = {cin, a[MSB:1]}; cout = a[0];   end
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [OP_W-1:0] op_sel,
  input  logic [DW-1:0]   acc_in,
  input  logic [DW-1:0]   mem_in,
  input  logic            carry_in,
  input  logic            dec_in,
  output logic [DW-1:0]   result,
  output logic            n_out,
  output logic            v_out,
  output logic            z_out,
  output logic            c_out,
  output logic            upd_n,
  output logic            upd_v,
  output logic            upd_z,
  output logic            upd_c
);
  localparam int MSB = DW - 1;

  logic          as_sub, as_dec, as_cin;
  logic [DW-1:0] as_sum, as_bin;
  logic          as_cout, as_ovf;
  logic [1:0]    lg_sel, sh_mode;
  logic [DW-1:0] lg_y, sh_y;
  logic          sh_cout;
  logic [OP_W-1:0] sh_code;

  // Operand steering for the shared adder: compare is a forced binary A - M
  always_comb begin
    as_sub = (op_sel == OP_SUB) || (op_sel == OP_CMP);
    as_dec = (op_sel != OP_CMP) && dec_in;
    as_cin = (op_sel == OP_CMP) ? 1'b1 : carry_in;
    case (op_sel)
      OP_OR:   lg_sel = 2'd1;
      OP_XOR:  lg_sel = 2'd2;
      default: lg_sel = 2'd0;
    endcase
    sh_code = op_sel - OP_SHL;
    sh_mode = sh_code[1:0];
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .subtract (as_sub),
    .decimal  (as_dec),
    .cin      (as_cin),
    .a        (acc_in),
    .b        (mem_in),
    .sum      (as_sum),
    .bin_sum  (as_bin),
    .cout     (as_cout),
    .ovf      (as_ovf)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .sel (lg_sel),
    .a   (acc_in),
    .b   (mem_in),
    .y   (lg_y)
  );

  alu8_shift #(.DW(DW)) u_shift (
    .mode (sh_mode),
    .cin  (carry_in),
    .a    (acc_in),
    .y    (sh_y),
    .cout (sh_cout)
  );

  // Result select, flag values and update masks
  always_comb begin
    result = acc_in;
    n_out  = 1'b0;
    v_out  = 1'b0;
    z_out  = 1'b0;
    c_out  = 1'b0;
    upd_n  = 1'b0;
    upd_v  = 1'b0;
    upd_z  = 1'b0;
    upd_c  = 1'b0;
    case (op_sel)
      OP_ADD, OP_SUB: begin
        result = as_sum;
        n_out  = as_bin[MSB];
        z_out  = (as_bin == '0);
        v_out  = as_ovf;
        c_out  = as_cout;
        {upd_n, upd_v, upd_z, upd_c} = 4'b1111;
      end
      OP_AND, OP_OR, OP_XOR: begin
        result = lg_y;
        n_out  = lg_y[MSB];
        z_out  = (lg_y == '0);
        {upd_n, upd_z} = 2'b11;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        result = sh_y;
        n_out  = sh_y[MSB];
        z_out  = (sh_y == '0);
        c_out  = sh_cout;
        {upd_n, upd_z, upd_c} = 3'b111;
      end
      OP_CMP: begin
        n_out = as_bin[MSB];
        z_out = (as_bin == '0);
        c_out = as_cout;
        {upd_n, upd_z, upd_c} = 3'b111;
      end
      OP_BIT: begin
        n_out = mem_in[MSB];
        v_out = mem_in[MSB-1];
        z_out = (lg_y == '0);
        {upd_n, upd_v, upd_z} = 3'b111;
      end
      default: ;
    endcase
  end

  // Embedded checks, evaluated only on fully known inputs
  always_comb begin
    if (!$isunknown({op_sel, acc_in, mem_in, carry_in, dec_in})) begin
      if (op_sel > OP_LAST) begin
        AST_UNUSED_PASS: assert (result == acc_in && !(upd_n || upd_v || upd_z || upd_c)) else $error("unused code altered state"); // R1
      end
      AST_MASKED_LOW: assert ((upd_n || !n_out) && (upd_v || !v_out) && (upd_z || !z_out) && (upd_c || !c_out)) else $error("masked flag not low"); // R1
      if (op_sel == OP_ADD && !dec_in) begin
        AST_ADD_ZERO: assert (z_out == (result == '0)) else $error("add zero flag"); // R2
      end
      if (op_sel == OP_SHL || op_sel == OP_ROL) begin
        AST_LEFT_CARRY: assert (c_out == acc_in[MSB]) else $error("left carry"); // R7
      end
      if (op_sel == OP_ROR) begin
        AST_ROR_FILL: assert (result[MSB] == carry_in && c_out == acc_in[0]) else $error("ror fill"); // R8
      end
      if (op_sel == OP_CMP) begin
        AST_CMP_ORDER: assert (z_out == (acc_in == mem_in) && c_out == (acc_in >= mem_in) && result == acc_in) else $error("compare"); // R9
      end
      if (op_sel == OP_BIT) begin
        AST_BIT_COPY: assert (n_out == mem_in[MSB] && v_out == mem_in[MSB-1] && result == acc_in) else $error("bit test"); // R10
      end
    end
  end
endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk = 1'b0;
  logic [3:0] op_sel;
  logic [7:0] acc_in, mem_in;
  logic       carry_in, dec_in;
  logic [7:0] result;
  logic       n_out, v_out, z_out, c_out;
  logic       upd_n, upd_v, upd_z, upd_c;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  alu8_core #(.DW(8)) dut (
    .op_sel (op_sel), .acc_in (acc_in), .mem_in (mem_in),
    .carry_in (carry_in), .dec_in (dec_in), .result (result),
    .n_out (n_out), .v_out (v_out), .z_out (z_out), .c_out (c_out),
    .upd_n (upd_n), .upd_v (upd_v), .upd_z (upd_z), .upd_c (upd_c)
  );

  function automatic int bcd2i(input int x);
    return ((x >> 4) & 15) * 10 + (x & 15);
  endfunction

  function automatic int i2bcd(input int x);
    return ((x / 10) << 4) | (x % 10);
  endfunction

  function automatic int sx(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // Expected model: r result, f = {N,V,Z,C}, u = update enables {N,V,Z,C}
  task automatic model(input int op, input int a, input int m, input int c, input int d,
                       output logic [7:0] r, output logic [3:0] f, output logic [3:0] u);
    int s, sv;
    r = a[7:0]; f = 4'b0000; u = 4'b0000;
    case (op)
      0, 1: begin
        if (op == 0) begin s = a + m + c; sv = sx(a) + sx(m) + c; end
        else begin s = a - m - (1 - c); sv = sx(a) - sx(m) - (1 - c); end
        r = s[7:0];
        f[3] = r[7];
        f[2] = (sv > 127) || (sv < -128);
        f[1] = (r == 8'd0);
        f[0] = (op == 0) ? (s > 255) : (s >= 0);
        if (d != 0) begin
          if (op == 0) s = bcd2i(a) + bcd2i(m) + c;
          else         s = bcd2i(a) - bcd2i(m) - (1 - c);
          f[0] = (op == 0) ? (s >= 100) : (s >= 0);
          s = (s + 100) % 100;
          r = i2bcd(s);
        end
        u = 4'b1111;
      end
      2, 3, 4: begin
        s = (op == 2) ? (a & m) : (op == 3) ? (a | m) : (a ^ m);
        r = s[7:0]; f = {r[7], 1'b0, r == 8'd0, 1'b0}; u = 4'b1010;
      end
      5, 6, 7, 8: begin
        case (op)
          5: begin s = (a << 1) & 255;             f[0] = (a >> 7) & 1; end
          6: begin s = a >> 1;                     f[0] = a & 1; end
          7: begin s = ((a << 1) & 255) | c;       f[0] = (a >> 7) & 1; end
          default: begin s = (a >> 1) | (c << 7); f[0] = a & 1; end
        endcase
        r = s[7:0]; f[3] = r[7]; f[1] = (r == 8'd0); u = 4'b1011;
      end
      9: begin
        s = (a - m + 256) & 255;
        f = {s[7], 1'b0, a == m, a >= m}; u = 4'b1011;
      end
      10: begin
        f = {m[7], m[6], (a & m) == 0, 1'b0}; u = 4'b1110;
      end
      default: ;
    endcase
  endtask

  task automatic check_vec(input int op, input int a, input int m, input int c, input int d,
                           input string req);
    logic [7:0] er; logic [3:0] ef, eu;
    op_sel = op[3:0]; acc_in = a[7:0]; mem_in = m[7:0];
    carry_in = c[0]; dec_in = d[0];
    #1;
    model(op, a, m, c, d, er, ef, eu);
    checks++;
    if ({result, n_out, v_out, z_out, c_out, upd_n, upd_v, upd_z, upd_c} !== {er, ef, eu}) begin
      errors++;
      $display("FAIL %s op=%0d a=%h m=%h c=%0d d=%0d: got res=%h f=%b u=%b exp res=%h f=%b u=%b",
               req, op, a, m, c, d, result, {n_out, v_out, z_out, c_out},
               {upd_n, upd_v, upd_z, upd_c}, er, ef, eu);
    end
  endtask

  function automatic string req_of(input int op, input int d);
    if (d != 0 && op > 1) return "R11";
    case (op)
      0: return (d != 0) ? "R4" : "R2";
      1: return (d != 0) ? "R5" : "R3";
      2, 3, 4: return "R6";
      5, 6: return "R7";
      7, 8: return "R8";
      9: return "R9";
      10: return "R10";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired: got %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Idle state with an unused code (R1)
    check_vec(15, 8'h5A, 8'hA5, 1, 1, "R1");

    // Directed corner cases
    check_vec(0, 8'h7F, 8'h01, 0, 0, "R2");   // signed overflow into 0x80
    check_vec(0, 8'hFF, 8'h01, 0, 0, "R2");   // zero with carry out
    check_vec(1, 8'h80, 8'h01, 1, 0, "R3");   // 0x7F with V set
    check_vec(1, 8'h00, 8'h01, 1, 0, "R3");   // borrow clears C
    check_vec(0, 8'h99, 8'h01, 0, 1, "R4");   // decimal wrap to 00
    check_vec(1, 8'h00, 8'h01, 1, 1, "R5");   // decimal borrow to 99
    check_vec(9, 8'h42, 8'h42, 0, 1, "R9");
    check_vec(10, 8'h0F, 8'hC0, 0, 0, "R10");

    // Strided binary sweep of every code, both carries and decimal settings
    for (int op = 0; op < 16; op++)
      for (int d = 0; d < 2; d++) begin
        if (op > 1 || d == 0)
          for (int a = 0; a < 256; a += 3)
            for (int m = 0; m < 256; m += 15)
              for (int c = 0; c < 2; c++)
                check_vec(op, a, m, c, d, req_of(op, d));
      end

    // Exhaustive valid packed-decimal sweep for add and subtract
    for (int op = 0; op < 2; op++)
      for (int x = 0; x < 100; x++)
        for (int y = 0; y < 100; y++)
          for (int c = 0; c < 2; c++)
            check_vec(op, i2bcd(x), i2bcd(y), c, 1, (op == 0) ? "R4" : "R5");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule